// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single pulse-width request into two gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. Neither switch is turned on until the other has been reported off by digital sense inputs and a programmed number of clock cycles has then elapsed. If the off report never arrives, a timeout stands in for it. The dead time therefore follows the real turn-off speed of the switches instead of a fixed worst-case figure.

The block also contains a startup crowbar. While the driver supply is above its arming level and the stage has not yet switched for the first time, a high switch node latches the low-side switch on. The latch releases only when the supply drops through its undervoltage level, or falls below the arming level. Two override inputs from the supervisor take priority over normal sequencing: one blanks both gates and one forces the low side on. All pins are plain level signals sampled on the rising clock edge. The gate enables are active high.

Top module: `deadtime_gate_sequencer`

## Requirements
- R1: While rst_n is low, hs_en and ls_en are both 0. The sequencer leaves reset in an all-off state and, on the first edge after reset, heads toward the side that pwm_req selects (1 = high side).
- R2: hs_en and ls_en are never 1 in the same cycle, under any input combination including the overrides.
- R3: When pwm_req is sampled 1 while the low side is on, ls_en drops at that edge. hs_en rises on the DT_HS_CYC-th edge after the edge that samples ls_off_sense = 1 (1 = low side confirmed off).
- R4: When pwm_req is sampled 0 while the high side is on, hs_en drops at that edge. ls_en rises on the DT_LS_CYC-th edge after the edge that samples hs_off_sense = 1.
- R5: If the off confirmation is still 0 on the SENSE_TIMEOUT_CYC-th edge after the turn-off edge, that edge counts as the confirmation, and the dead-time count starts from it.
- R6: If pwm_req reverses while the sequencer is waiting for a confirmation or counting dead time, it abandons the pending turn-on. It then sequences toward the other side through the full confirm-and-delay path, so no gate glitches on.
- R7: force_off = 1 drops both enables in the same cycle. After release, the first turn-on follows the full R3/R4 sequence.
- R8: force_ls = 1 (with force_off = 0) sets ls_en = 1 and hs_en = 0 in the same cycle. After release with pwm_req = 1, ls_en drops on the next edge and hs_en follows the R3 timing.
- R9: An edge that samples drv_arm = 1, sw_high = 1 and an open startup window sets the startup latch. From the next cycle, ls_en = 1 and hs_en = 0, and this holds after sw_high returns to 0.
- R10: The startup latch clears on the edge that first samples drv_uvlo_ok = 0 after it was 1, or on any edge that samples drv_arm = 0. A rise of drv_uvlo_ok does not clear it. Normal sequencing resumes from the low-side-on state.
- R11: The startup window closes on the first edge on which the sequencer enters its high-side-on state; sw_high is then ignored. It reopens on an edge that samples drv_arm = 0.
- R12: force_off has priority over force_ls and over the startup latch: with force_off = 1 both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | Modulator request, 1 = high side on, 0 = low side on |
| hs_off_sense | input | 1 | 1 = high-side switch sensed off |
| ls_off_sense | input | 1 | 1 = low-side switch sensed off |
| force_off | input | 1 | Supervisor override, 1 = both gates off |
| force_ls | input | 1 | Supervisor override, 1 = low-side gate on |
| drv_arm | input | 1 | 1 = driver supply above the crowbar arming level |
| drv_uvlo_ok | input | 1 | 1 = driver supply above its undervoltage level |
| sw_high | input | 1 | 1 = switch node above the startup trip level |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The startup latch and the first high-side turn-on can land on the same clock edge. The window closes on the edge that enters the high-side state, and that same edge may also set the latch. The bench reopens the window by dropping drv_arm, then raises sw_high so that it is sampled only on the edge where the high-side dead time expires. The pass criterion is that hs_en never appears: ls_en takes over in that cycle, and the latch holds and then releases on a supply dip. A later sw_high pulse must then leave the high side untouched.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LS_ON,
    ST_WAIT_LS,
    ST_DT_HS,
    ST_HS_ON,
    ST_WAIT_HS,
    ST_DT_LS
  } seq_state_t;

endpackage

// File: rtl/dts_countdown.sv
module dts_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));

endmodule

// File: rtl/dts_seq_fsm.sv
module dts_seq_fsm
  import dts_pkg::*;
#(
  parameter int DT_HS_CYC         = 3,
  parameter int DT_LS_CYC         = 2,
  parameter int SENSE_TIMEOUT_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm,
  input  logic       hs_off,
  input  logic       ls_off,
  input  logic       hold_off,
  input  logic       hold_ls,
  output seq_state_t state,
  output logic       hs_start
);

  localparam int DT_MAX  = (DT_HS_CYC > DT_LS_CYC) ? DT_HS_CYC : DT_LS_CYC;
  localparam int ALL_MAX = (DT_MAX > SENSE_TIMEOUT_CYC) ? DT_MAX : SENSE_TIMEOUT_CYC;
  localparam int CW      = $clog2(ALL_MAX + 1);

  seq_state_t state_q, state_d;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          tick_last;

  dts_countdown #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .last     (tick_last)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = CW'(SENSE_TIMEOUT_CYC);
    if (hold_off) begin
      state_d = ST_IDLE;
    end else if (hold_ls) begin
      state_d = ST_LS_ON;
    end else begin
      case (state_q)
        ST_IDLE: begin
          ld      = 1'b1;
          state_d = pwm ? ST_WAIT_LS : ST_WAIT_HS;
        end
        ST_LS_ON: begin
          if (pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_LS;
          end
        end
        ST_WAIT_LS: begin
          if (!pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_HS;
          end else if (ls_off || tick_last) begin
            ld      = 1'b1;
            ld_val  = CW'(DT_HS_CYC);
            state_d = ST_DT_HS;
          end
        end
        ST_DT_HS: begin
          if (!pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_HS;
          end else if (tick_last) begin
            state_d = ST_HS_ON;
          end
        end
        ST_HS_ON: begin
          if (!pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_HS;
          end
        end
        ST_WAIT_HS: begin
          if (pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_LS;
          end else if (hs_off || tick_last) begin
            ld      = 1'b1;
            ld_val  = CW'(DT_LS_CYC);
            state_d = ST_DT_LS;
          end
        end
        ST_DT_LS: begin
          if (pwm) begin
            ld      = 1'b1;
            state_d = ST_WAIT_LS;
          end else if (tick_last) begin
            state_d = ST_LS_ON;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign hs_start = (state_d == ST_HS_ON) && (state_q != ST_HS_ON);

endmodule

// File: rtl/dts_startup_trip.sv
module dts_startup_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic supply_ok,
  input  logic sw_high,
  input  logic seq_hs_start,
  output logic tripped
);

  logic supply_ok_q;
  logic window_q;
  logic trip_q;
  logic clear;

  // release on a downward crossing of the supply level, or on loss of arming
  assign clear = !arm || (supply_ok_q && !supply_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_ok_q <= 1'b0;
      window_q    <= 1'b1;
      trip_q      <= 1'b0;
    end else begin
      supply_ok_q <= supply_ok;
      if (!arm)              window_q <= 1'b1;
      else if (seq_hs_start) window_q <= 1'b0;
      if (clear)                              trip_q <= 1'b0;
      else if (arm && window_q && sw_high)    trip_q <= 1'b1;
    end
  end

  assign tripped = trip_q;

endmodule

// File: rtl/deadtime_gate_sequencer.sv
module deadtime_gate_sequencer
  import dts_pkg::*;
#(
  parameter int DT_HS_CYC         = 3,
  parameter int DT_LS_CYC         = 2,
  parameter int SENSE_TIMEOUT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic hs_off_sense,
  input  logic ls_off_sense,
  input  logic force_off,
  input  logic force_ls,
  input  logic drv_arm,
  input  logic drv_uvlo_ok,
  input  logic sw_high,
  output logic hs_en,
  output logic ls_en
);

  seq_state_t seq_state;
  logic       hs_start;
  logic       trip_q;
  logic       ovr_ls;

  assign ovr_ls = force_ls || trip_q;

  dts_seq_fsm #(
    .DT_HS_CYC         (DT_HS_CYC),
    .DT_LS_CYC         (DT_LS_CYC),
    .SENSE_TIMEOUT_CYC (SENSE_TIMEOUT_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm      (pwm_req),
    .hs_off   (hs_off_sense),
    .ls_off   (ls_off_sense),
    .hold_off (force_off),
    .hold_ls  (ovr_ls),
    .state    (seq_state),
    .hs_start (hs_start)
  );

  dts_startup_trip u_trip (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm          (drv_arm),
    .supply_ok    (drv_uvlo_ok),
    .sw_high      (sw_high),
    .seq_hs_start (hs_start),
    .tripped      (trip_q)
  );

  // priority: blank both, then low-side override, then sequencer state
  assign hs_en = !force_off && !ovr_ls && (seq_state == ST_HS_ON);
  assign ls_en = !force_off && (ovr_ls || (seq_state == ST_LS_ON));

endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
  parameter int DT_HS_CYC = 3,
  parameter int DT_LS_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic force_off,
  input logic force_ls,
  input logic drv_arm,
  input logic drv_uvlo_ok,
  input logic tripped,
  input logic hs_en,
  input logic ls_en
);

  logic [15:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                off_run <= '0;
    else if (hs_en || ls_en)   off_run <= '0;
    else if (off_run != 16'hFFFF) off_run <= off_run + 16'd1;
  end

  assert_never_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_force_off_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> (!hs_en && !ls_en));

  assert_force_ls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_ls && !force_off) |-> (ls_en && !hs_en));

  assert_trip_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !force_off) |-> (ls_en && !hs_en));

  assert_hs_deadtime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> (off_run >= 16'(DT_HS_CYC)));

  assert_ls_deadtime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_en) && !force_ls && !tripped) |-> (off_run >= 16'(DT_LS_CYC)));

  assert_trip_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv_uvlo_ok) || !drv_arm) |=> !tripped);

endmodule

bind deadtime_gate_sequencer dts_checker #(
  .DT_HS_CYC (DT_HS_CYC),
  .DT_LS_CYC (DT_LS_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .force_off   (force_off),
  .force_ls    (force_ls),
  .drv_arm     (drv_arm),
  .drv_uvlo_ok (drv_uvlo_ok),
  .tripped     (trip_q),
  .hs_en       (hs_en),
  .ls_en       (ls_en)
);

// File: tb/deadtime_gate_sequencer_tb.sv
module deadtime_gate_sequencer_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, pwm_req, hs_off_sense, ls_off_sense;
  logic force_off, force_ls, drv_arm, drv_uvlo_ok, sw_high;
  logic hs_en, ls_en;

  int n_chk = 0;
  int n_err = 0;
  int overlap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_gate_sequencer #(
    .DT_HS_CYC (3),
    .DT_LS_CYC (2),
    .SENSE_TIMEOUT_CYC (6)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_req      (pwm_req),
    .hs_off_sense (hs_off_sense),
    .ls_off_sense (ls_off_sense),
    .force_off    (force_off),
    .force_ls     (force_ls),
    .drv_arm      (drv_arm),
    .drv_uvlo_ok  (drv_uvlo_ok),
    .sw_high      (sw_high),
    .hs_en        (hs_en),
    .ls_en        (ls_en)
  );

  always @(negedge clk) if (rst_n && hs_en && ls_en) overlap++;

  task automatic chk(input string req, input string what, input logic [1:0] exp);
    n_chk++;
    if ({hs_en, ls_en} !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual {hs,ls}=%b expected=%b", req, what, {hs_en, ls_en}, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1, R9, R10: reset, latched crowbar, release on supply dip
  task automatic t_reset_trip();
    rst_n = 0; pwm_req = 1; hs_off_sense = 1; ls_off_sense = 1;
    force_off = 0; force_ls = 0; drv_arm = 1; drv_uvlo_ok = 0; sw_high = 1;
    nclk(3);
    chk("R1", "in reset", 2'b00);
    rst_n = 1;
    nclk(1); chk("R9", "crowbar sets", 2'b01);
    sw_high = 0;
    nclk(3); chk("R9", "crowbar holds", 2'b01);
    drv_uvlo_ok = 1;
    nclk(2); chk("R10", "supply rise keeps latch", 2'b01);
    drv_uvlo_ok = 0;
    nclk(1); chk("R10", "released, low side from state", 2'b01);
    nclk(1); chk("R10", "resumes sequencing", 2'b00);
    nclk(3); chk("R3", "dead time not yet done", 2'b00);
    nclk(1); chk("R3", "high side after dead time", 2'b10);
  endtask

  task automatic t_fall();
    pwm_req = 0;
    nclk(1); chk("R4", "high side drops", 2'b00);
    nclk(2); chk("R4", "dead time running", 2'b00);
    nclk(1); chk("R4", "low side on", 2'b01);
  endtask

  task automatic t_rise_plain();
    pwm_req = 1;
    nclk(4); chk("R3", "before high side", 2'b00);
    nclk(1); chk("R3", "high side on", 2'b10);
  endtask

  task automatic t_rise_sense();
    ls_off_sense = 0; pwm_req = 1;
    nclk(1); chk("R3", "low side drops at first edge", 2'b00);
    nclk(2); ls_off_sense = 1;
    nclk(3); chk("R3", "waits for confirm plus delay", 2'b00);
    nclk(1); chk("R3", "high side exact edge", 2'b10);
  endtask

  task automatic t_timeout();
    t_fall();
    ls_off_sense = 0; pwm_req = 1;
    nclk(9); chk("R5", "timeout plus delay pending", 2'b00);
    nclk(1); chk("R5", "high side after timeout", 2'b10);
    ls_off_sense = 1;
  endtask

  task automatic t_abort();
    t_fall();
    ls_off_sense = 0; pwm_req = 1;
    nclk(2); chk("R6", "waiting", 2'b00);
    pwm_req = 0;
    nclk(3); chk("R6", "no high pulse, still off", 2'b00);
    nclk(1); chk("R6", "back to low side", 2'b01);
    ls_off_sense = 1;
    t_rise_plain();
  endtask

  task automatic t_force_off();
    force_off = 1; #1;
    chk("R7", "immediate blank", 2'b00);
    nclk(2); chk("R7", "held blank", 2'b00);
    force_off = 0;
    nclk(4); chk("R7", "full sequence after release", 2'b00);
    nclk(1); chk("R7", "high side back", 2'b10);
  endtask

  task automatic t_force_ls();
    force_ls = 1; #1;
    chk("R8", "immediate low side", 2'b01);
    nclk(2); chk("R8", "held low side", 2'b01);
    force_ls = 0;
    nclk(1); chk("R8", "low side drops after release", 2'b00);
    nclk(3); chk("R8", "dead time", 2'b00);
    nclk(1); chk("R8", "high side", 2'b10);
  endtask

  task automatic t_both();
    force_off = 1; force_ls = 1; #1;
    chk("R12", "blank beats low-side override", 2'b00);
    nclk(2); force_off = 0; force_ls = 0;
    nclk(4); chk("R12", "sequence after release", 2'b00);
    nclk(1); chk("R12", "high side", 2'b10);
  endtask

  // R11 with the crowbar landing on the high-side turn-on edge
  task automatic t_window();
    drv_arm = 0;
    nclk(1); drv_arm = 1;
    chk("R11", "arm drop leaves high side", 2'b10);
    t_fall();
    pwm_req = 1;
    nclk(4); chk("R11", "dead time", 2'b00);
    sw_high = 1;
    nclk(1); chk("R11", "crowbar wins coincident edge", 2'b01);
    sw_high = 0;
    nclk(1); force_off = 1; #1;
    chk("R12", "blank beats crowbar", 2'b00);
    nclk(1); force_off = 0;
    nclk(1); chk("R9", "crowbar still latched", 2'b01);
    drv_uvlo_ok = 1;
    nclk(2); drv_uvlo_ok = 0;
    nclk(5); chk("R10", "resequencing", 2'b00);
    nclk(1); chk("R10", "high side after release", 2'b10);
    sw_high = 1;
    nclk(2); chk("R11", "window closed, switch node ignored", 2'b10);
    sw_high = 0;
  endtask

  initial begin
    t_reset_trip();
    t_fall();
    t_rise_sense();
    t_timeout();
    t_abort();
    t_force_off();
    t_force_ls();
    t_both();
    t_window();
    n_chk++;
    if (overlap != 0) begin
      n_err++;
      $display("FAIL R2 overlap cycles: actual=%0d expected=0", overlap);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule